// File: doc/BRIEF.md
# Link Integrity Monitor

This block watches the receive half of a 10BASE-T twisted-pair link and decides whether the link may carry packets. It takes three single-cycle inputs: a millisecond tick, a strobe for each received normal link pulse, and a strobe for each received packet. It drives a link-good status and a packet-transmit enable. When the enable is low, the transmitter must hold back packets. Idle link pulse generation carries on regardless, because that happens outside this block.

While the link is good, every received pulse or packet restarts a loss timer. If the timer reaches its limit before any receive activity arrives, the link is declared failed. A failed link recovers in one of two ways. A single received packet restores it, and its contents play no part in the decision. Two link pulses also restore it, provided their spacing is more than a lower bound and no more than an upper bound. All limits are parameters counted in ticks, so a bench can shorten them.

Top module: `link_integrity_monitor`

## Requirements
- R1: After reset, linkGood and txEnable are both 0 (link failed).
- R2: While good, a pulse or packet strobe clears the loss timer. If LOSS_TICKS ticks then arrive with no strobe, linkGood drops in the cycle after the LOSS_TICKS-th tick.
- R3: While failed, a packet strobe sets linkGood in the following cycle, whatever the state of the pulse checker.
- R4: While failed, a second pulse sets linkGood in the following cycle when the number of ticks seen strictly between the two pulse strobes is greater than MIN_GAP and no more than MAX_GAP.
- R5: While failed, a second pulse with MIN_GAP or fewer ticks since the first leaves the link failed. That pulse becomes the first pulse of a new pair.
- R6: While failed, the (MAX_GAP+1)-th tick after the first pulse abandons the pair. The next pulse then starts a new pair and does not restore the link.
- R7: txEnable equals linkGood in every cycle.
- R8: A tick in the same cycle as a pulse or packet strobe is not counted by either timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msTick | input | 1 | One-cycle strobe, once per millisecond |
| linkPulseIn | input | 1 | One-cycle strobe per received normal link pulse |
| packetIn | input | 1 | One-cycle strobe per received packet |
| linkGood | output | 1 | Link judged usable |
| txEnable | output | 1 | Packet transmission allowed |

## Verification
The hardest situations to reach are the exact edges of the pulse-spacing window. These are a second pulse after exactly MIN_GAP or MAX_GAP ticks, and a pulse landing just after the pair was abandoned on the (MAX_GAP+1)-th tick. The bench shrinks the parameters and drives a precise number of tick strobes between pulse strobes to hit each edge. It also places a tick on the very cycle of a strobe when the loss timer sits one tick from expiry. A behavioural model tracks every cycle in parallel with these checks.

// File: rtl/lim_pkg.sv
package lim_pkg;

  typedef enum logic {
    LINK_FAIL = 1'b0,
    LINK_OK   = 1'b1
  } linkState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic clrLoss;
    logic incLoss;
    logic clrGap;
    logic incGap;
    logic arm;
    logic disarm;
  } limCmd_t;

  // flags from the datapath back to control
  typedef struct packed {
    logic lossLast;
    logic gapShort;
    logic gapLast;
    logic armed;
  } limStat_t;

endpackage

// File: rtl/lim_timers.sv
module lim_timers
  import lim_pkg::*;
#(
  parameter int LOSS_TICKS = 75,
  parameter int MIN_GAP    = 6,
  parameter int MAX_GAP    = 50
) (
  input  logic     clk,
  input  logic     rstN,
  input  limCmd_t  cmd,
  output limStat_t stat
);

  localparam int LW = $clog2(LOSS_TICKS + 1);
  localparam int GW = $clog2(MAX_GAP + 1);
  localparam logic [LW-1:0] LOSS_LAST = LW'(LOSS_TICKS - 1);
  localparam logic [GW-1:0] GAP_MIN   = GW'(MIN_GAP);
  localparam logic [GW-1:0] GAP_MAX   = GW'(MAX_GAP);

  logic [LW-1:0] lossCnt;
  logic [GW-1:0] gapCnt;
  logic          armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lossCnt <= '0;
    end else if (cmd.clrLoss) begin
      lossCnt <= '0;
    end else if (cmd.incLoss) begin
      lossCnt <= lossCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
      armed  <= 1'b0;
    end else begin
      if (cmd.clrGap) begin
        gapCnt <= '0;
      end else if (cmd.incGap) begin
        gapCnt <= gapCnt + 1'b1;
      end
      if (cmd.arm) begin
        armed <= 1'b1;
      end else if (cmd.disarm) begin
        armed <= 1'b0;
      end
    end
  end

  assign stat.lossLast = (lossCnt == LOSS_LAST);
  assign stat.gapShort = (gapCnt <= GAP_MIN);
  assign stat.gapLast  = (gapCnt == GAP_MAX);
  assign stat.armed    = armed;

  p_loss_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    lossCnt < LW'(LOSS_TICKS));

  p_gap_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= GAP_MAX);

  p_clear_loss_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrLoss |=> lossCnt == '0);

endmodule

// File: rtl/lim_ctrl.sv
module lim_ctrl
  import lim_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     msTick,
  input  logic     linkPulseIn,
  input  logic     packetIn,
  input  limStat_t stat,
  output limCmd_t  cmd,
  output logic     isGood
);

  linkState_t state, stateNext;
  logic activity;

  assign activity = linkPulseIn | packetIn;

  always_comb begin
    cmd       = '0;
    stateNext = state;
    unique case (state)
      LINK_OK: begin
        if (activity) begin
          cmd.clrLoss = 1'b1;
        end else if (msTick) begin
          if (stat.lossLast) begin
            stateNext  = LINK_FAIL;
            cmd.disarm = 1'b1;
            cmd.clrGap = 1'b1;
          end else begin
            cmd.incLoss = 1'b1;
          end
        end
      end
      default: begin
        if (packetIn) begin
          stateNext   = LINK_OK;
          cmd.clrLoss = 1'b1;
          cmd.disarm  = 1'b1;
        end else if (linkPulseIn) begin
          if (stat.armed && !stat.gapShort) begin
            stateNext   = LINK_OK;
            cmd.clrLoss = 1'b1;
            cmd.disarm  = 1'b1;
          end else begin
            cmd.arm    = 1'b1;
            cmd.clrGap = 1'b1;
          end
        end else if (msTick && stat.armed) begin
          if (stat.gapLast) begin
            cmd.disarm = 1'b1;
          end else begin
            cmd.incGap = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= LINK_FAIL;
    end else begin
      state <= stateNext;
    end
  end

  assign isGood = (state == LINK_OK);

  p_rise_needs_rx_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isGood) |-> $past(activity));

  p_fall_needs_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(isGood) |-> $past(msTick && !activity));

  p_packet_restores_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!isGood && packetIn) |=> isGood);

  p_good_holds_on_rx_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isGood && activity) |=> isGood);

endmodule

// File: rtl/link_integrity_monitor.sv
module link_integrity_monitor
  import lim_pkg::*;
#(
  parameter int LOSS_TICKS = 75,
  parameter int MIN_GAP    = 6,
  parameter int MAX_GAP    = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic linkPulseIn,
  input  logic packetIn,
  output logic linkGood,
  output logic txEnable
);

  limCmd_t  cmd;
  limStat_t stat;
  logic     isGood;

  lim_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .msTick      (msTick),
    .linkPulseIn (linkPulseIn),
    .packetIn    (packetIn),
    .stat        (stat),
    .cmd         (cmd),
    .isGood      (isGood)
  );

  lim_timers #(
    .LOSS_TICKS (LOSS_TICKS),
    .MIN_GAP    (MIN_GAP),
    .MAX_GAP    (MAX_GAP)
  ) u_timers (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .stat (stat)
  );

  assign linkGood = isGood;
  assign txEnable = isGood;

  p_enable_tracks_r7: assert property (@(posedge clk) disable iff (!rstN)
    txEnable == linkGood);

endmodule

// File: tb/sim_link_integrity_monitor.sv
`timescale 1ns/1ps
module sim_link_integrity_monitor;

  localparam int LOSS = 12;
  localparam int MINV = 3;
  localparam int MAXV = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic linkPulseIn = 1'b0;
  logic packetIn = 1'b0;
  logic linkGood;
  logic txEnable;

  int nRun = 0;
  int nFail = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  link_integrity_monitor #(.LOSS_TICKS(LOSS), .MIN_GAP(MINV), .MAX_GAP(MAXV)) u0 (
    .clk(clk), .rstN(rstN), .msTick(msTick), .linkPulseIn(linkPulseIn),
    .packetIn(packetIn), .linkGood(linkGood), .txEnable(txEnable)
  );

  // behavioural reference: ticks since last activity, and ticks since pair start
  bit mGood;
  int quietTicks;
  int pairAge;      // -1 when no pair is open
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mGood <= 1'b0; quietTicks <= 0; pairAge <= -1;
    end else if (mGood) begin
      if (linkPulseIn || packetIn) quietTicks <= 0;
      else if (msTick) begin
        if (quietTicks + 1 == LOSS) begin mGood <= 1'b0; pairAge <= -1; end
        else quietTicks <= quietTicks + 1;
      end
    end else begin
      if (packetIn) begin mGood <= 1'b1; quietTicks <= 0; pairAge <= -1; end
      else if (linkPulseIn) begin
        if (pairAge > MINV) begin mGood <= 1'b1; quietTicks <= 0; pairAge <= -1; end
        else pairAge <= 0;
      end else if (msTick && pairAge >= 0) begin
        pairAge <= (pairAge + 1 > MAXV) ? -1 : pairAge + 1;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rstN) begin
      nRun++;
      if (linkGood !== mGood || txEnable !== linkGood) begin
        nFail++;
        $display("FAIL %s model: linkGood=%0b txEnable=%0b expected %0b", tag, linkGood, txEnable, mGood);
      end
    end
  end

  task automatic check(input string req, input bit exp);
    nRun++;
    if (linkGood !== exp || txEnable !== exp) begin
      nFail++;
      $display("FAIL %s: linkGood=%0b txEnable=%0b expected %0b", req, linkGood, txEnable, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input bit t, input bit p, input bit k);
    @(negedge clk);
    msTick = t; linkPulseIn = p; packetIn = k;
    @(negedge clk);
    msTick = 0; linkPulseIn = 0; packetIn = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin strobe(1, 0, 0); idle(2); end
  endtask

  initial begin
    #20000;
    nFail++;
    $display("FAIL watchdog: timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    idle(3);
    check("R1", 1'b0);
    rstN = 1'b1;
    idle(2);
    check("R1", 1'b0);

    tag = "R3"; strobe(0, 0, 1); check("R3", 1'b1);

    tag = "R2"; ticks(LOSS - 1); check("R2", 1'b1);
    strobe(0, 1, 0); ticks(LOSS - 1); check("R2", 1'b1);
    ticks(1); check("R2", 1'b0);

    tag = "R5"; strobe(0, 1, 0); ticks(MINV); strobe(0, 1, 0); check("R5", 1'b0);
    ticks(MINV + 1); strobe(0, 1, 0); check("R5", 1'b1);

    tag = "R8"; ticks(LOSS - 1); strobe(1, 1, 0); check("R8", 1'b1);
    ticks(LOSS - 1); check("R8", 1'b1);
    ticks(1); check("R2", 1'b0);

    tag = "R4"; strobe(0, 1, 0); ticks(MAXV); strobe(0, 1, 0); check("R4", 1'b1);
    ticks(LOSS); check("R2", 1'b0);

    tag = "R6"; strobe(0, 1, 0); ticks(MAXV + 1); strobe(0, 1, 0); check("R6", 1'b0);
    ticks(MINV + 1); strobe(0, 1, 0); check("R6", 1'b1);
    ticks(LOSS); check("R2", 1'b0);

    tag = "R8"; strobe(0, 1, 0); ticks(MINV); strobe(1, 1, 0); check("R8", 1'b0);

    tag = "R3"; strobe(0, 1, 0); strobe(0, 0, 1); check("R3", 1'b1);
    ticks(LOSS); check("R2", 1'b0);

    idle(4);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule